// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block receives asynchronous serial frames on a single line and hands each byte to a host over a small register bus. A frame is one start bit, eight data bits sent least significant bit first, an optional even or odd parity bit, and one stop bit. The line is sampled at sixteen times the bit rate, using a one-cycle enable pulse supplied from outside. Each byte is built up in a shift stage. When the stop bit arrives, the byte moves into a data holding register.

A status byte reports the state of the receiver. It shows whether the holding register has a byte waiting, whether a byte was lost, and whether the last byte had a parity or framing fault. It also shows the carrier-detect level and the transmit-empty level, which is an input taken from a transmitter outside this block. Two enable bits select which conditions drive the receive and transmit interrupt outputs. A bit in the control register clears the error flags when software writes a zero to it.

When carrier-detect is high, or the I/O-stop input is active, the receiver is held idle and every receive flag is forced clear.

Top module: `uart_rx_stat`

## Requirements
- R1: With parity off, a frame carrying data value D (least significant bit first, 16 ticks per bit) loads D into the holding register, which is read at address 0. The frame also sets status bit 7 (data ready).
- R2: Reading address 1 returns the status byte. Bits 7 to 0 are, in order: data ready, overrun, parity error, framing error, receive-interrupt enable, carrier-detect level, transmit-empty input, transmit-interrupt enable.
- R3: After reset the status byte reads 0x00 when the carrier-detect and transmit-empty inputs are low. A write to address 1 changes only bit 3 and bit 0. For example, writing 0xFF with transmit-empty high reads back 0x0B.
- R4: Control register at address 2: bit 1 enables parity and bit 2 selects odd parity. A byte whose parity bit does not give the selected parity is still loaded and still sets data ready, and it also sets status bit 5. A byte with correct parity leaves bit 5 clear.
- R5: A stop bit sampled low sets status bit 4, and the byte is still loaded. The receiver then does not look for a new start bit until the line has returned high.
- R6: A read of address 0 clears data ready on the next clock edge.
- R7: If a byte completes while data ready is set and no read of address 0 happens in that cycle, the overrun flag (bit 6) is set. The holding register keeps the unread byte and the new byte is discarded.
- R8: A write to address 2 with bit 0 equal to 0 clears the overrun, parity and framing flags. It leaves data ready unchanged.
- R9: While carrier-detect or I/O-stop is high, status bits 7 to 4 read 0 and no frame on the line is received.
- R10: The receive interrupt output is high exactly when bit 3 is set and at least one of status bits 7 to 4 is set.
- R11: The transmit interrupt output is high exactly when bit 0 is set and the transmit-empty input is high.
- R12: A low pulse on the line that is shorter than half a bit time is rejected as a false start bit and produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Sample enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial receive line, idles high |
| dcd | input | 1 | Carrier-detect level; high forces the receiver idle |
| iostop | input | 1 | I/O-stop; high forces the receiver idle |
| tdre | input | 1 | Transmit-empty level from the external transmitter |
| bus_addr | input | 2 | Register address (0 data, 1 status, 2 control) |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The read data is combinational, so the bench samples it one nanosecond after driving the address, in the same cycle. Reads and writes change flags on the next rising edge, so the bench checks the status byte in the cycle after the strobe. A completed byte becomes visible one edge after the receiver samples the middle of the stop bit. That point is two synchronizer cycles plus about eight ticks into the stop bit, so the bench waits until the whole stop bit has been driven plus a margin of four cycles before it reads. The interrupt outputs are combinational from the flags, and the bench checks them in the same cycle as the status read that shows those flags.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int RX_ADDR_DATA = 0;
  localparam int RX_ADDR_STAT = 1;
  localparam int RX_ADDR_CTRL = 2;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4,
    S_BRK   = 3'd5
  } rx_state_e;

  // Expected parity bit for a byte under even (odd=0) or odd (odd=1) parity
  function automatic logic parity_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  function automatic logic [7:0] pack_status(
    input logic rdy, input logic ovr, input logic pe, input logic fe,
    input logic rie, input logic cd, input logic txe, input logic tie);
    return {rdy, ovr, pe, fe, rie, cd, txe, tie};
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              hold,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ferr
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

  rx_state_e         st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [DATA_W-1:0] shreg;
  logic              pbit;
  logic              at_half, at_full;

  assign at_half = (cnt == HALF);
  assign at_full = (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      pbit  <= 1'b0;
      done  <= 1'b0;
      data  <= '0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
    end else if (hold) begin
      st   <= S_IDLE;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: begin
            cnt <= '0;
            if (!rxd) st <= S_START;
          end
          S_START: begin
            if (at_half) begin
              cnt  <= '0;
              bitn <= '0;
              st   <= rxd ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (at_full) begin
              cnt   <= '0;
              shreg <= {rxd, shreg[DATA_W-1:1]};
              bitn  <= bitn + 1'b1;
              if (bitn == LAST) st <= par_en ? S_PAR : S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (at_full) begin
              cnt  <= '0;
              pbit <= rxd;
              st   <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (at_full) begin
              cnt  <= '0;
              done <= 1'b1;
              data <= shreg;
              ferr <= !rxd;
              perr <= par_en && (pbit != parity_of(shreg, par_odd));
              st   <= rxd ? S_IDLE : S_BRK;
            end else cnt <= cnt + 1'b1;
          end
          S_BRK: begin
            cnt <= '0;
            if (rxd) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (st == S_IDLE)) else $error("hold did not idle");        // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle");        // R1
  AST_FE_WAITS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ferr) |-> (st == S_BRK)) else $error("no line-high wait"); // R5
endmodule

// File: rtl/rx_status.sv
module rx_status
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              perr,
  input  logic              ferr,
  input  logic              dcd,
  input  logic              iostop,
  input  logic              tdre,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              par_en,
  output logic              par_odd
);
  logic [DATA_W-1:0] rdr;
  logic rdrf, ovrn, pe, fe, rie, tie;
  logic clr_all, rd_data, wr_stat, wr_ctrl, efr_clr, load, ovr_evt;

  assign clr_all = dcd | iostop;
  assign rd_data = rd && (addr == ADDR_W'(RX_ADDR_DATA));
  assign wr_stat = wr && (addr == ADDR_W'(RX_ADDR_STAT));
  assign wr_ctrl = wr && (addr == ADDR_W'(RX_ADDR_CTRL));
  assign efr_clr = wr_ctrl && !wdata[0];
  assign load    = done && (!rdrf || rd_data);
  assign ovr_evt = done && rdrf && !rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr <= '0;
      rdrf <= 1'b0;
      ovrn <= 1'b0;
      pe <= 1'b0;
      fe <= 1'b0;
    end else if (clr_all) begin
      rdrf <= 1'b0;
      ovrn <= 1'b0;
      pe <= 1'b0;
      fe <= 1'b0;
    end else begin
      if (load) begin
        rdr  <= rx_data;
        rdrf <= 1'b1;
      end else if (rd_data) rdrf <= 1'b0;

      if (ovr_evt)      ovrn <= 1'b1;
      else if (efr_clr) ovrn <= 1'b0;

      if (load) begin
        pe <= perr;
        fe <= ferr;
      end else if (efr_clr) begin
        pe <= 1'b0;
        fe <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rie <= 1'b0;
      tie <= 1'b0;
      par_en <= 1'b0;
      par_odd <= 1'b0;
    end else begin
      if (wr_stat) begin
        rie <= wdata[3];
        tie <= wdata[0];
      end
      if (wr_ctrl) begin
        par_en  <= wdata[1];
        par_odd <= wdata[2];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(RX_ADDR_DATA): rdata = 8'(rdr);
      ADDR_W'(RX_ADDR_STAT): rdata = pack_status(rdrf, ovrn, pe, fe, rie, dcd, tdre, tie);
      ADDR_W'(RX_ADDR_CTRL): rdata = {5'b0, par_odd, par_en, 1'b1};
      default:               rdata = '0;
    endcase
  end

  assign irq_rx = rie && (rdrf || ovrn || pe || fe);
  assign irq_tx = tie && tdre;

  AST_RDRF_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr_all) |=> rdrf) else $error("load without ready");      // R1
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done) |=> !rdrf) else $error("read left ready set");    // R6
  AST_OVR_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !clr_all) |=> (ovrn && $stable(rdr))) else $error("overrun"); // R7
  AST_EFR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (efr_clr && !done) |=> (!ovrn && !pe && !fe)) else $error("efr clear");   // R8
  AST_FORCE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (!rdrf && !ovrn && !pe && !fe)) else $error("force clear");   // R9
endmodule

// File: rtl/uart_rx_stat.sv
module uart_rx_stat #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              dcd,
  input  logic              iostop,
  input  logic              tdre,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic              rxd_s, hold, done, perr, ferr, par_en, par_odd;
  logic [DATA_W-1:0] rx_data;

  assign hold = dcd | iostop;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

  rx_shifter #(.DATA_W(DATA_W), .OSR(OSR)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd_s), .hold(hold),
    .par_en(par_en), .par_odd(par_odd), .done(done), .data(rx_data),
    .perr(perr), .ferr(ferr));

  rx_status #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .done(done), .rx_data(rx_data), .perr(perr),
    .ferr(ferr), .dcd(dcd), .iostop(iostop), .tdre(tdre), .addr(bus_addr),
    .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata), .rdata(bus_rdata),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .par_en(par_en), .par_odd(par_odd));
endmodule

// File: tb/tb_uart_rx_stat.sv
`timescale 1ns/1ps
module tb_uart_rx_stat;
  logic clk = 0, rst_n = 0, tick16 = 1, rxd = 1, dcd = 0, iostop = 0, tdre = 0;
  logic [1:0] bus_addr = 0;
  logic bus_rd = 0, bus_wr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq_rx, irq_tx;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  uart_rx_stat dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wr = 1; bus_wdata = v;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic line_bit(input logic b);
    @(negedge clk); rxd = b;
    repeat (15) @(negedge clk);
  endtask

  // par: 0 none, 1 even, 2 odd; flip inverts the parity bit; stop is the stop level
  task automatic send(input logic [7:0] d, input int par, input logic flip, input logic stop);
    int ones = 0;
    line_bit(1'b0);
    for (int i = 0; i < 8; i++) begin
      line_bit(d[i]);
      if (d[i]) ones++;
    end
    if (par != 0) line_bit(((ones % 2 == 1) ^ (par == 2)) ^ flip);
    line_bit(stop);
    @(negedge clk); rxd = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_read(1, v); chk("R3 reset status", v, 8'h00);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    send(8'hA5, 0, 0, 1);
    bus_read(1, v); chk("R1/R2 ready bit", v, 8'h80);
    bus_read(0, v); chk("R1 data", v, 8'hA5);
    bus_read(1, v); chk("R6 ready cleared", v, 8'h00);
  endtask

  task automatic t_enables;
    logic [7:0] v;
    tdre = 1;
    bus_write(1, 8'hFF);
    bus_read(1, v); chk("R3 writable bits", v, 8'h0B);
    chk("R11 irq_tx on", {7'b0, irq_tx}, 8'h01);
    chk("R10 irq_rx off", {7'b0, irq_rx}, 8'h00);
    @(negedge clk); tdre = 0; #1;
    chk("R11 irq_tx off", {7'b0, irq_tx}, 8'h00);
    bus_write(1, 8'h00);
  endtask

  task automatic t_parity;
    logic [7:0] v;
    bus_write(2, 8'h03);
    send(8'h3C, 1, 0, 1);
    bus_read(1, v); chk("R4 even ok", v, 8'h80);
    bus_read(0, v); chk("R4 even data", v, 8'h3C);
    bus_write(2, 8'h07);
    send(8'h3C, 2, 1, 1);
    bus_read(1, v); chk("R4 odd error", v, 8'hA0);
    bus_write(1, 8'h08);
    @(negedge clk); chk("R10 irq_rx on", {7'b0, irq_rx}, 8'h01);
    bus_read(0, v); chk("R4 errored data", v, 8'h3C);
    bus_read(1, v); chk("R6 pe stays", v, 8'h28);
    chk("R10 irq_rx pe", {7'b0, irq_rx}, 8'h01);
    bus_write(2, 8'h06);
    bus_read(1, v); chk("R8 pe cleared", v, 8'h08);
    chk("R10 irq_rx off", {7'b0, irq_rx}, 8'h00);
    bus_write(1, 8'h00);
    bus_write(2, 8'h01);
  endtask

  task automatic t_framing;
    logic [7:0] v;
    send(8'h5A, 0, 0, 0);
    bus_read(1, v); chk("R5 fe set", v, 8'h90);
    bus_read(0, v); chk("R5 data", v, 8'h5A);
    bus_write(2, 8'h00);
    repeat (40) @(negedge clk);
    bus_read(1, v); chk("R5/R8 no spurious", v, 8'h00);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    send(8'h11, 0, 0, 1);
    send(8'h22, 0, 0, 1);
    bus_read(1, v); chk("R7 overrun", v, 8'hC0);
    bus_write(2, 8'h00);
    bus_read(1, v); chk("R8 ready kept", v, 8'h80);
    bus_read(0, v); chk("R7 old byte kept", v, 8'h11);
    bus_read(1, v); chk("R6 after read", v, 8'h00);
  endtask

  task automatic t_hold;
    logic [7:0] v;
    send(8'h33, 0, 0, 1);
    @(negedge clk); dcd = 1;
    bus_read(1, v); chk("R9 dcd clears", v, 8'h04);
    send(8'h77, 0, 0, 1);
    @(negedge clk); dcd = 0;
    repeat (4) @(negedge clk);
    bus_read(1, v); chk("R9 dcd no rx", v, 8'h00);
    send(8'h44, 0, 0, 1);
    @(negedge clk); iostop = 1;
    bus_read(1, v); chk("R9 iostop clears", v, 8'h00);
    send(8'h66, 0, 0, 1);
    @(negedge clk); iostop = 0;
    repeat (4) @(negedge clk);
    bus_read(1, v); chk("R9 iostop no rx", v, 8'h00);
  endtask

  task automatic t_glitch;
    logic [7:0] v;
    @(negedge clk); rxd = 0;
    repeat (4) @(negedge clk);
    rxd = 1;
    repeat (60) @(negedge clk);
    bus_read(1, v); chk("R12 glitch rejected", v, 8'h00);
    send(8'hC3, 0, 0, 1);
    bus_read(0, v); chk("R12 recovers", v, 8'hC3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_enables();
    t_parity();
    t_framing();
    t_overrun();
    t_hold();
    t_glitch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule